// File: doc/BRIEF.md
# Bit-Test Conditional Branch Unit

This unit executes the three-byte bit-test-and-branch instructions of an 8-bit processor. A start pulse hands it the opcode and the address that opcode was fetched from. The unit then reads the two operand bytes that follow the opcode. The first is a direct-page address. The second is a signed branch offset. It then reads the byte at that direct-page address and tests the one bit the opcode selects.

The test is true when the bit is set or when it is clear, depending on the polarity bit in the opcode. A true test gives a program counter of the next-instruction address plus the sign-extended offset. A false test gives the next-instruction address only. In both cases the tested bit is copied to a carry output. A one-cycle done pulse marks the end of each instruction.

Memory is reached through a byte-wide read port. The port has a registered address and read strobe, and the data returns one cycle later, which matches an inferred block RAM.

Top module: `bittest_branch`

## Requirements
- R1: After an accepted start, the unit issues exactly three reads in this order: opcode address + 1 (direct address byte), opcode address + 2 (offset byte), then the tested byte.
- R2: The tested byte is read at the direct address byte zero-extended to the full address width, so the upper address bits of that read are zero.
- R3: Opcode bits [3:1] give the tested bit number (0 to 7), and opcode bit 0 selects branch-on-clear (1) or branch-on-set (0). Opcode bits [7:4] must equal the ROW parameter (default 0); a start with any other upper nibble is ignored, so no read and no done follow.
- R4: When the test is true, `taken` is 1 and `pc_next` = opcode address + 3 + sign-extended offset, modulo 2^AW. This gives a reach of -128 to +127 from the next instruction.
- R5: When the test is false, `taken` is 0 and `pc_next` = opcode address + 3, modulo 2^AW.
- R6: `carry` equals the value of the tested bit, whether or not the branch is taken.
- R7: `done` is high for exactly one cycle per accepted instruction. A start raised while an instruction is in progress is ignored.
- R8: `done` rises on the fourth rising edge after the edge that samples `start`. `taken`, `carry` and `pc_next` are valid while `done` is high and hold until the next done.
- R9: `mem_rdata` must hold the byte at `mem_addr` in the cycle after an edge that samples `mem_rd` high. `mem_rd` is low whenever the unit is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (sampled while idle) |
| opcode | input | 8 | Bit-test-branch opcode |
| pc_in | input | AW | Address of the opcode byte |
| mem_addr | output | AW | Read address (registered) |
| mem_rd | output | 1 | Read strobe (registered) |
| mem_rdata | input | 8 | Read data, one cycle after the strobe |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Branch taken |
| carry | output | 1 | Copy of the tested bit |
| pc_next | output | AW | Next program counter |

## Verification
The tested byte is tried with one-hot and one-cold patterns for every bit number. This separates an error in bit selection from an error in polarity, because only the selected bit differs from its neighbours.

Offsets of +127, -128 and small values, along with an instruction placed at the top of the address space, show whether the offset is sign-extended and whether the sum wraps. A direct address of 0xFF is used with different data placed at an aliased high address, which exposes sign-extension of the direct address. The remaining directed cases cover a start pulse during a busy instruction and an opcode outside the reserved row, which show that stray starts are rejected.

// File: rtl/bittest_branch_pkg.sv
package bittest_branch_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GET_DIR,
    ST_GET_OFS,
    ST_GET_OPND,
    ST_EVAL
  } bb_state_e;
endpackage

// File: rtl/bittest_seq.sv
module bittest_seq
  import bittest_branch_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int OPW = 8,
  parameter int SW  = 3,
  parameter logic [OPW-SW-2:0] ROW = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [OPW-1:0] opcode,
  input  logic [AW-1:0]  pc_in,
  input  logic [DW-1:0]  mem_rdata,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_rd,
  output logic [SW:0]    op_q,
  output logic [AW-1:0]  base_q,
  output logic [DW-1:0]  ofs_q,
  output logic           eval
);
  localparam int PADW = AW - DW;

  bb_state_e st;
  logic      row_ok;

  assign row_ok = (opcode[OPW-1:SW+1] == ROW);
  assign eval   = (st == ST_EVAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      mem_addr <= '0;
      mem_rd   <= 1'b0;
      op_q     <= '0;
      base_q   <= '0;
      ofs_q    <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start && row_ok) begin
            op_q     <= opcode[SW:0];
            base_q   <= pc_in;
            mem_addr <= pc_in + AW'(1);
            mem_rd   <= 1'b1;
            st       <= ST_GET_DIR;
          end
        end
        ST_GET_DIR: begin
          mem_addr <= base_q + AW'(2);
          mem_rd   <= 1'b1;
          st       <= ST_GET_OFS;
        end
        ST_GET_OFS: begin
          // direct address byte is on mem_rdata now
          mem_addr <= {{PADW{1'b0}}, mem_rdata};
          mem_rd   <= 1'b1;
          st       <= ST_GET_OPND;
        end
        ST_GET_OPND: begin
          ofs_q  <= mem_rdata;
          mem_rd <= 1'b0;
          st     <= ST_EVAL;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R1: first read targets the byte after the opcode
  a_r1_first_fetch: assert property (@(posedge clk) disable iff (rst)
    (st == ST_GET_DIR) |-> (mem_rd && mem_addr == base_q + AW'(1)));
  // R2: operand read stays inside the direct page
  a_r2_zero_ext: assert property (@(posedge clk) disable iff (rst)
    (st == ST_GET_OPND) |-> (mem_addr[AW-1:DW] == '0));
  // R9: no read strobe while idle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !mem_rd);
endmodule

// File: rtl/bittest_cond.sv
module bittest_cond #(
  parameter int DW = 8,
  parameter int SW = 3
) (
  input  logic [DW-1:0] operand,
  input  logic [SW:0]   op_sel,
  output logic          bit_val,
  output logic          take
);
  logic [DW-1:0] hit;

  // one-hot select of the tested bit
  for (genvar g = 0; g < DW; g++) begin : g_sel
    assign hit[g] = operand[g] && (op_sel[SW:1] == SW'(g));
  end

  assign bit_val = |hit;
  assign take    = bit_val ^ op_sel[0];
endmodule

// File: rtl/bittest_target.sv
module bittest_target #(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int INSN_L = 3
) (
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] ofs,
  input  logic          take,
  output logic [AW-1:0] target
);
  localparam int PADW = AW - DW;
  logic [AW-1:0] seq_pc;
  logic [AW-1:0] ofs_ext;

  assign seq_pc  = base + AW'(INSN_L);
  assign ofs_ext = {{PADW{ofs[DW-1]}}, ofs};
  assign target  = take ? (seq_pc + ofs_ext) : seq_pc;
endmodule

// File: rtl/bittest_branch.sv
module bittest_branch #(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int OPW = 8,
  parameter logic [OPW-$clog2(DW)-2:0] ROW = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [OPW-1:0] opcode,
  input  logic [AW-1:0]  pc_in,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_rd,
  input  logic [DW-1:0]  mem_rdata,
  output logic           done,
  output logic           taken,
  output logic           carry,
  output logic [AW-1:0]  pc_next
);
  localparam int SW     = $clog2(DW);
  localparam int INSN_L = 3;

  logic [SW:0]   op_q;
  logic [AW-1:0] base_q;
  logic [DW-1:0] ofs_q;
  logic          eval;
  logic          bit_val;
  logic          take;
  logic [AW-1:0] target;

  bittest_seq #(.AW(AW), .DW(DW), .OPW(OPW), .SW(SW), .ROW(ROW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .pc_in(pc_in),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .op_q(op_q), .base_q(base_q), .ofs_q(ofs_q), .eval(eval)
  );

  bittest_cond #(.DW(DW), .SW(SW)) u_cond (
    .operand(mem_rdata), .op_sel(op_q), .bit_val(bit_val), .take(take)
  );

  bittest_target #(.AW(AW), .DW(DW), .INSN_L(INSN_L)) u_target (
    .base(base_q), .ofs(ofs_q), .take(take), .target(target)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      taken   <= 1'b0;
      carry   <= 1'b0;
      pc_next <= '0;
    end else begin
      done <= eval;
      if (eval) begin
        taken   <= take;
        carry   <= bit_val;
        pc_next <= target;
      end
    end
  end

  // R7: done is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R6: carry and taken differ exactly when branching on clear
  a_r6_carry_polarity: assert property (@(posedge clk) disable iff (rst)
    done |-> ((carry ^ taken) == op_q[0]));
  // R5: fall-through goes to the instruction after the three bytes
  a_r5_fall_through: assert property (@(posedge clk) disable iff (rst)
    (done && !taken) |-> (pc_next == base_q + AW'(INSN_L)));
  // R8: results are stable while done is high
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!eval && !done) |=> $stable(pc_next));
endmodule

// File: tb/bittest_branch_bench.sv
module bittest_branch_bench;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic [7:0]    opcode;
  logic [AW-1:0] pc_in;
  logic [AW-1:0] mem_addr;
  logic          mem_rd;
  logic [7:0]    mem_rdata;
  logic          done, taken, carry;
  logic [AW-1:0] pc_next;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int rd_cnt = 0;
  logic [AW-1:0] log0, log1, log2;
  logic [7:0] mem [1024];

  always #4 clk = ~clk;

  bittest_branch u_bittest_branch (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .pc_in(pc_in),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .done(done), .taken(taken), .carry(carry), .pc_next(pc_next)
  );

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= mem[mem_addr[9:0]];
      log0 <= log1; log1 <= log2; log2 <= mem_addr;
      rd_cnt <= rd_cnt + 1;
    end
    if (done) done_cnt <= done_cnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_br(input logic [7:0] op, input logic [AW-1:0] pc,
                        input logic [7:0] dir, input logic [7:0] ofs,
                        input logic [7:0] data, input bit poke, input string tag);
    logic bitv, tk;
    logic [AW-1:0] exp_pc;
    int n;
    int d0;
    mem[10'(pc + 16'd1)] = dir;
    mem[10'(pc + 16'd2)] = ofs;
    mem[10'(dir)] = data;
    bitv = data[op[3:1]];
    tk = op[0] ? !bitv : bitv;
    exp_pc = pc + 16'd3 + (tk ? {{8{ofs[7]}}, ofs} : 16'd0);
    d0 = done_cnt;
    @(negedge clk); opcode = op; pc_in = pc; start = 1'b1;
    @(negedge clk); start = 1'b0; n = 1;
    if (poke) begin
      opcode = op ^ 8'h01; start = 1'b1;
    end
    while (!done && n < 20) begin
      @(negedge clk); n++;
      start = 1'b0;
    end
    chk(n == 5, {tag, " R8 latency"}, n, 5);
    chk(taken == tk, {tag, " R4/R5 taken"}, taken, tk);
    chk(pc_next == exp_pc, {tag, tk ? " R4 target" : " R5 fall-through"}, pc_next, exp_pc);
    chk(carry == bitv, {tag, " R6 carry"}, carry, bitv);
    chk(log0 == pc + 16'd1 && log1 == pc + 16'd2, {tag, " R1 fetch order"},
        {log0, log1}, {pc + 16'd1, pc + 16'd2});
    chk(log2 == {8'h00, dir}, {tag, " R2 operand address"}, log2, {8'h00, dir});
    @(negedge clk);
    chk(!done && pc_next == exp_pc, {tag, " R7/R8 single pulse, hold"}, done, 0);
    if (poke) begin
      repeat (8) @(negedge clk);
      chk(done_cnt == d0 + 1, {tag, " R7 busy start ignored"}, done_cnt - d0, 1);
    end
  endtask

  task automatic t_reset();
    chk(!done && !mem_rd && pc_next == '0, "reset R9", {done, mem_rd}, 0);
  endtask

  task automatic t_bits();
    for (int b = 0; b < 8; b++) begin
      // one-hot: set-test on b taken (R3)
      run_br({4'h0, 3'(b), 1'b0}, 16'h0100, 8'h40, 8'h10, 8'(1 << b), 0, "R3 set onehot");
      // one-cold: clear-test on b taken
      run_br({4'h0, 3'(b), 1'b1}, 16'h0120, 8'h41, 8'hF0, ~8'(1 << b), 0, "R3 clear onecold");
      // one-hot on neighbour: set-test on b falls through
      run_br({4'h0, 3'(b), 1'b0}, 16'h0140, 8'h42, 8'h22, 8'(1 << ((b + 1) % 8)), 0, "R3 set neighbour");
    end
  endtask

  task automatic t_offsets();
    run_br(8'h0E, 16'h0200, 8'h50, 8'h7F, 8'h80, 0, "R4 max fwd");
    run_br(8'h0F, 16'h0210, 8'h51, 8'h80, 8'h00, 0, "R4 max back");
    run_br(8'h01, 16'h0220, 8'h52, 8'h80, 8'h01, 0, "R5 clear not taken");
    run_br(8'h04, 16'hFFFE, 8'h60, 8'h05, 8'h04, 0, "R4 wrap");
  endtask

  task automatic t_direct_page();
    mem[10'h3FF] = 8'h00;
    run_br(8'h00, 16'h0300, 8'hFF, 8'h08, 8'h01, 0, "R2 dp top");
  endtask

  task automatic t_busy();
    run_br(8'h06, 16'h0400, 8'h70, 8'h0C, 8'h08, 1, "R7 busy");
  endtask

  task automatic t_row();
    int d0, r0;
    d0 = done_cnt; r0 = rd_cnt;
    @(negedge clk); opcode = 8'h31; pc_in = 16'h0500; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (8) @(negedge clk);
    chk(done_cnt == d0 && rd_cnt == r0, "R3 outside row ignored", done_cnt - d0, 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'hA5;
    rst = 1'b1; start = 1'b0; opcode = '0; pc_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_bits();
    t_offsets();
    t_direct_page();
    t_busy();
    t_row();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule